// File: doc/BRIEF.md
# Single-Slot Deferred Access Target Controller

This block sits behind the target side of a bus slave and lends that bus a shared memory port on which the bus has the lowest priority. Each request is one data phase; bursts are not accepted. If the port's arbiter offers the port in the cycle the request is seen, the block reads or writes at once and reports completion. If the port is busy, a write is accepted and parked as a posted write, and a read is parked as a deferred read that answers with a retry until its data has been fetched and the same read comes back.

Only one transaction can be parked at a time. Conflicting traffic gets a retry, or for a write that collides with parked work, an error that throws away both the parked work and the new write. A sticky error flag and two pending flags give software a view of the slot. Reads that carry an address parity error are aborted; writes that carry one are acknowledged and dropped.

The command field's bit 0 selects direction (1 = write, 0 = read). The other command bits are qualifiers that take part in matching a returning deferred read. The response codes on `rsp_code` are 1 = complete, 2 = retry, 3 = target abort. Every response is registered and appears in the cycle after the request.

Top module: `dfr_target_ctrl`

## Requirements
- R1: With no parked work and `mem_gnt` high, a request without parity error accesses memory in the same cycle (`mem_en` high, `mem_addr` = request address, `mem_we` = command bit 0). The next cycle shows `rsp_valid` with code 1, and for a read `rsp_rdata` holds the word at that address.
- R2: A write arriving with no parked work and `mem_gnt` low is answered with code 1, sets `pw_pending`, and holds `mem_req` high until a cycle with `mem_gnt`. It is written to memory in that grant cycle, and `pw_pending` and `mem_req` are low from the next cycle.
- R3: A read arriving while `pw_pending` is high is answered with code 2 (retry) and leaves the parked write in place.
- R4: A write arriving while `pw_pending` is high is answered with code 1 and sets `err_flag`. Neither the parked write nor the new write reaches memory, even if `mem_gnt` is high in that cycle, and `pw_pending` clears.
- R5: A read arriving with no parked work and `mem_gnt` low captures its address and full command, sets `rd_pending`, raises `mem_req`, and is answered with code 2.
- R6: Until the parked read's data has been fetched (the grant cycle and the cycle after it), every read is answered with code 2, matching or not.
- R7: After the fetch, a read whose address and full command equal the parked ones is answered with code 1 and the fetched data, and `rd_pending` clears. A read differing in address or in any command bit gets code 2, and the data stays held.
- R8: A write arriving while `rd_pending` is high is answered with code 1, sets `err_flag`, clears `rd_pending`, and does not reach memory.
- R9: A read with `bus_aperr` high is answered with code 3 (abort), touches no memory and parks nothing.
- R10: A write with `bus_aperr` high is answered with code 1, but memory is not written and nothing is parked.
- R11: `err_flag` stays set until a cycle with `err_clr` high. A new error in the same cycle as `err_clr` leaves it set.
- R12: After reset `rsp_valid`, `mem_req`, `pw_pending`, `rd_pending` and `err_flag` are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_req | input | 1 | Single-phase request strobe |
| bus_cmd | input | CMD_W | Command; bit 0 = write, other bits are qualifiers |
| bus_addr | input | ADDR_W | Word address |
| bus_wdata | input | DATA_W | Write data |
| bus_aperr | input | 1 | Address parity error seen on this request |
| rsp_valid | output | 1 | Response present (cycle after request) |
| rsp_code | output | 2 | 1 complete, 2 retry, 3 abort |
| rsp_rdata | output | DATA_W | Read data for a completed read |
| mem_req | output | 1 | Parked work needs the memory port |
| mem_gnt | input | 1 | Port offered to this block this cycle |
| mem_en | output | 1 | Memory access this cycle |
| mem_we | output | 1 | Access is a write |
| mem_addr | output | ADDR_W | Memory address |
| mem_wdata | output | DATA_W | Memory write data |
| mem_rdata | input | DATA_W | Memory read data, one cycle after a read |
| err_clr | input | 1 | Write-one-to-clear for the error flag |
| err_flag | output | 1 | Sticky conflict error |
| pw_pending | output | 1 | A posted write is parked |
| rd_pending | output | 1 | A deferred read is parked |

## Verification
The bench builds the block with a 4-bit address, 16-bit data and a 2-bit command. This small command still has one qualifier bit, so a returning read that matches on address but differs in its qualifier can be exercised. The small address space lets the bench model memory and read back every address the dropped or parity-flagged writes might have reached. Because the arbiter's offer is driven per cycle, the bench can place a grant exactly on the cycle of a colliding write and on the fetch-to-capture cycle of a deferred read.

// File: rtl/dfr_pkg.sv
package dfr_pkg;

  typedef enum logic [1:0] {
    RSP_NONE  = 2'd0,
    RSP_DONE  = 2'd1,
    RSP_RETRY = 2'd2,
    RSP_ABORT = 2'd3
  } rsp_e;

  typedef enum logic [2:0] {
    SL_IDLE,
    SL_PW,
    SL_RD_WAIT,
    SL_RD_LOAD,
    SL_RD_READY
  } slot_e;

  typedef enum logic [2:0] {
    OP_NONE,
    OP_POST,
    OP_PARK_RD,
    OP_DROP,
    OP_HIT
  } slot_op_e;

endpackage

// File: rtl/dfr_decide.sv
module dfr_decide
  import dfr_pkg::*;
(
  input  logic     req,
  input  logic     is_wr,
  input  logic     aperr,
  input  logic     gnt,
  input  logic     hit,
  input  slot_e    st,
  output rsp_e     code,
  output slot_op_e op,
  output logic     imm,
  output logic     err_set
);

  always_comb begin
    code    = RSP_NONE;
    op      = OP_NONE;
    imm     = 1'b0;
    err_set = 1'b0;
    if (req) begin
      if (aperr) begin
        code = is_wr ? RSP_DONE : RSP_ABORT;
      end else begin
        unique case (st)
          SL_IDLE: begin
            if (gnt) begin
              imm  = 1'b1;
              code = RSP_DONE;
            end else if (is_wr) begin
              op   = OP_POST;
              code = RSP_DONE;
            end else begin
              op   = OP_PARK_RD;
              code = RSP_RETRY;
            end
          end
          SL_RD_READY: begin
            if (is_wr) begin
              op      = OP_DROP;
              err_set = 1'b1;
              code    = RSP_DONE;
            end else if (hit) begin
              op   = OP_HIT;
              code = RSP_DONE;
            end else begin
              code = RSP_RETRY;
            end
          end
          default: begin
            if (is_wr) begin
              op      = OP_DROP;
              err_set = 1'b1;
              code    = RSP_DONE;
            end else begin
              code = RSP_RETRY;
            end
          end
        endcase
      end
    end
  end

endmodule

// File: rtl/dfr_slot.sv
module dfr_slot
  import dfr_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter int DATA_W = 32,
  parameter int CMD_W  = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  slot_op_e          op,
  input  logic              gnt,
  input  logic [ADDR_W-1:0] in_addr,
  input  logic [CMD_W-1:0]  in_cmd,
  input  logic [DATA_W-1:0] in_wdata,
  input  logic [DATA_W-1:0] mem_rdata,
  output slot_e             st,
  output logic              hit,
  output logic              use_en,
  output logic              use_we,
  output logic [ADDR_W-1:0] use_addr,
  output logic [DATA_W-1:0] held_data,
  output logic              pw_pending,
  output logic              rd_pending,
  output logic              need_port
);

  slot_e             st_q;
  logic [ADDR_W-1:0] addr_q;
  logic [CMD_W-1:0]  cmd_q;
  logic [DATA_W-1:0] data_q;

  assign st         = st_q;
  assign hit        = (addr_q == in_addr) && (cmd_q == in_cmd);
  assign need_port  = (st_q == SL_PW) || (st_q == SL_RD_WAIT);
  assign use_en     = need_port && gnt && (op != OP_DROP);
  assign use_we     = (st_q == SL_PW);
  assign use_addr   = addr_q;
  assign held_data  = data_q;
  assign pw_pending = (st_q == SL_PW);
  assign rd_pending = (st_q == SL_RD_WAIT) || (st_q == SL_RD_LOAD) ||
                      (st_q == SL_RD_READY);

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q <= SL_IDLE;
    end else begin
      unique case (op)
        OP_POST:    st_q <= SL_PW;
        OP_PARK_RD: st_q <= SL_RD_WAIT;
        OP_DROP:    st_q <= SL_IDLE;
        OP_HIT:     st_q <= SL_IDLE;
        default: begin
          unique case (st_q)
            SL_PW:      if (gnt) st_q <= SL_IDLE;
            SL_RD_WAIT: if (gnt) st_q <= SL_RD_LOAD;
            SL_RD_LOAD: st_q <= SL_RD_READY;
            default:    st_q <= st_q;
          endcase
        end
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (op == OP_POST || op == OP_PARK_RD) begin
      addr_q <= in_addr;
      cmd_q  <= in_cmd;
    end
    if (op == OP_POST) begin
      data_q <= in_wdata;
    end else if (st_q == SL_RD_LOAD && op != OP_DROP) begin
      data_q <= mem_rdata;
    end
  end

endmodule

// File: rtl/dfr_errflag.sv
module dfr_errflag (
  input  logic clk,
  input  logic rst,
  input  logic set,
  input  logic clr,
  output logic flag
);

  logic flag_q;
  assign flag = flag_q;

  always_ff @(posedge clk) begin
    if (rst)      flag_q <= 1'b0;
    else if (set) flag_q <= 1'b1;
    else if (clr) flag_q <= 1'b0;
  end

  // R11
  err_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    flag_q && !clr |=> flag_q);

  // R11
  err_set_chk: assert property (@(posedge clk) disable iff (rst)
    set |=> flag_q);

endmodule

// File: rtl/dfr_target_ctrl.sv
module dfr_target_ctrl
  import dfr_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter int DATA_W = 32,
  parameter int CMD_W  = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_req,
  input  logic [CMD_W-1:0]  bus_cmd,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  input  logic              bus_aperr,
  output logic              rsp_valid,
  output logic [1:0]        rsp_code,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic              mem_req,
  input  logic              mem_gnt,
  output logic              mem_en,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  input  logic [DATA_W-1:0] mem_rdata,
  input  logic              err_clr,
  output logic              err_flag,
  output logic              pw_pending,
  output logic              rd_pending
);

  localparam int WR_BIT = 0;

  logic              is_wr;
  rsp_e              code;
  slot_op_e          op;
  logic              imm;
  logic              err_set;
  slot_e             st;
  logic              hit;
  logic              use_en;
  logic              use_we;
  logic [ADDR_W-1:0] use_addr;
  logic [DATA_W-1:0] held_data;

  rsp_e rsp_q;
  logic rsp_mem_q;

  assign is_wr = bus_cmd[WR_BIT];

  dfr_decide u_decide (
    .req     (bus_req),
    .is_wr   (is_wr),
    .aperr   (bus_aperr),
    .gnt     (mem_gnt),
    .hit     (hit),
    .st      (st),
    .code    (code),
    .op      (op),
    .imm     (imm),
    .err_set (err_set)
  );

  dfr_slot #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .CMD_W(CMD_W)) u_slot (
    .clk        (clk),
    .rst        (rst),
    .op         (op),
    .gnt        (mem_gnt),
    .in_addr    (bus_addr),
    .in_cmd     (bus_cmd),
    .in_wdata   (bus_wdata),
    .mem_rdata  (mem_rdata),
    .st         (st),
    .hit        (hit),
    .use_en     (use_en),
    .use_we     (use_we),
    .use_addr   (use_addr),
    .held_data  (held_data),
    .pw_pending (pw_pending),
    .rd_pending (rd_pending),
    .need_port  (mem_req)
  );

  dfr_errflag u_err (
    .clk  (clk),
    .rst  (rst),
    .set  (err_set),
    .clr  (err_clr),
    .flag (err_flag)
  );

  // Memory port: parked work and immediate access never coincide,
  // since an immediate access needs an empty slot.
  always_comb begin
    mem_en    = use_en | imm;
    mem_we    = use_en ? use_we : is_wr;
    mem_addr  = use_en ? use_addr : bus_addr;
    mem_wdata = use_en ? held_data : bus_wdata;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_q     <= RSP_NONE;
      rsp_mem_q <= 1'b0;
    end else begin
      rsp_q     <= code;
      rsp_mem_q <= imm && !is_wr;
    end
  end

  assign rsp_valid = (rsp_q != RSP_NONE);
  assign rsp_code  = rsp_q;
  assign rsp_rdata = rsp_mem_q ? mem_rdata : held_data;

  // R1
  imm_access_chk: assert property (@(posedge clk) disable iff (rst)
    bus_req && !bus_aperr && mem_gnt && !pw_pending && !rd_pending
    |-> mem_en && mem_addr == bus_addr && mem_we == is_wr);

  // R2
  mem_req_hold_chk: assert property (@(posedge clk) disable iff (rst)
    mem_req && !mem_gnt && !bus_req |=> mem_req);

  // R3
  pw_read_retry_chk: assert property (@(posedge clk) disable iff (rst)
    pw_pending && bus_req && !is_wr && !bus_aperr |=> rsp_code == RSP_RETRY);

  // R6
  early_read_retry_chk: assert property (@(posedge clk) disable iff (rst)
    (st == SL_RD_WAIT || st == SL_RD_LOAD) && bus_req && !is_wr && !bus_aperr
    |=> rsp_code == RSP_RETRY);

  // R9
  aperr_abort_chk: assert property (@(posedge clk) disable iff (rst)
    bus_req && bus_aperr && !is_wr |=> rsp_code == RSP_ABORT);

endmodule

// File: tb/sim_dfr_target_ctrl.sv
`timescale 1ns/1ps
module sim_dfr_target_ctrl;

  localparam int AW = 4;
  localparam int DW = 16;
  localparam int CW = 2;
  localparam int NV = 30;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          bus_req = 1'b0;
  logic [CW-1:0] bus_cmd = '0;
  logic [AW-1:0] bus_addr = '0;
  logic [DW-1:0] bus_wdata = '0;
  logic          bus_aperr = 1'b0;
  logic          rsp_valid;
  logic [1:0]    rsp_code;
  logic [DW-1:0] rsp_rdata;
  logic          mem_req;
  logic          mem_gnt = 1'b0;
  logic          mem_en;
  logic          mem_we;
  logic [AW-1:0] mem_addr;
  logic [DW-1:0] mem_wdata;
  logic [DW-1:0] mem_rdata;
  logic          err_clr = 1'b0;
  logic          err_flag;
  logic          pw_pending;
  logic          rd_pending;

  int n_run  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  always #2.5 clk = ~clk;

  dfr_target_ctrl #(.ADDR_W(AW), .DATA_W(DW), .CMD_W(CW)) u0 (
    .clk(clk), .rst(rst), .bus_req(bus_req), .bus_cmd(bus_cmd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_aperr(bus_aperr),
    .rsp_valid(rsp_valid), .rsp_code(rsp_code), .rsp_rdata(rsp_rdata),
    .mem_req(mem_req), .mem_gnt(mem_gnt), .mem_en(mem_en), .mem_we(mem_we),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
    .err_clr(err_clr), .err_flag(err_flag), .pw_pending(pw_pending),
    .rd_pending(rd_pending)
  );

  // Memory model: synchronous, read data one cycle after the enable.
  logic [DW-1:0] mem [1<<AW];
  always @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < (1 << AW); i++) mem[i] <= '0;
      mem_rdata <= '0;
    end else if (mem_en) begin
      if (mem_we) mem[mem_addr] <= mem_wdata;
      else        mem_rdata <= mem[mem_addr];
    end
  end

  // Vector: [35:32] req tag, [31] req, [30:29] cmd, [28] aperr, [27] gnt,
  // [26] clr, [25:22] addr, [21:6] data/expected rdata, [5:4] code,
  // [3] check rdata, [2] pw, [1] rd, [0] err
  function automatic logic [35:0] v(int rq, bit rv, logic [1:0] cmd, bit ap,
      bit g, bit c, logic [3:0] a, logic [15:0] d, logic [1:0] cd, bit ck,
      bit pw, bit rp, bit er);
    return {rq[3:0], rv, cmd, ap, g, c, a, d, cd, ck, pw, rp, er};
  endfunction

  function automatic string rq_name(int n);
    case (n)
      1: return "R1";   2: return "R2";   3: return "R3";   4: return "R4";
      5: return "R5";   6: return "R6";   7: return "R7";   8: return "R8";
      9: return "R9";   10: return "R10"; 11: return "R11"; 12: return "R12";
      default: return "R?";
    endcase
  endfunction

  localparam logic [35:0] VEC [NV] = '{
    v(1, 1, 2'b01, 0, 1, 0, 4'd3, 16'h1111, 2'd1, 0, 0, 0, 0), // R1 write
    v(1, 1, 2'b00, 0, 1, 0, 4'd3, 16'h1111, 2'd1, 1, 0, 0, 0), // R1 read
    v(2, 1, 2'b01, 0, 0, 0, 4'd5, 16'h2222, 2'd1, 0, 1, 0, 0), // R2 post
    v(3, 1, 2'b00, 0, 0, 0, 4'd5, 16'h0000, 2'd2, 0, 1, 0, 0), // R3
    v(2, 0, 2'b00, 0, 1, 0, 4'd0, 16'h0000, 2'd0, 0, 0, 0, 0), // R2 commit
    v(2, 1, 2'b00, 0, 1, 0, 4'd5, 16'h2222, 2'd1, 1, 0, 0, 0), // R2 data
    v(5, 1, 2'b00, 0, 0, 0, 4'd5, 16'h0000, 2'd2, 0, 0, 1, 0), // R5 park
    v(6, 1, 2'b00, 0, 0, 0, 4'd5, 16'h0000, 2'd2, 0, 0, 1, 0), // R6 same
    v(6, 0, 2'b00, 0, 1, 0, 4'd0, 16'h0000, 2'd0, 0, 0, 1, 0), // R6 fetch
    v(6, 1, 2'b10, 0, 0, 0, 4'd5, 16'h0000, 2'd2, 0, 0, 1, 0), // R6 load
    v(7, 1, 2'b00, 0, 0, 0, 4'd3, 16'h0000, 2'd2, 0, 0, 1, 0), // R7 addr
    v(7, 1, 2'b10, 0, 0, 0, 4'd5, 16'h0000, 2'd2, 0, 0, 1, 0), // R7 cmd
    v(7, 1, 2'b00, 0, 0, 0, 4'd5, 16'h2222, 2'd1, 1, 0, 0, 0), // R7 hit
    v(4, 1, 2'b01, 0, 0, 0, 4'd6, 16'h3333, 2'd1, 0, 1, 0, 0), // R4 post
    v(4, 1, 2'b01, 0, 1, 0, 4'd7, 16'h4444, 2'd1, 0, 0, 0, 1), // R4 clash
    v(4, 1, 2'b00, 0, 1, 0, 4'd6, 16'h0000, 2'd1, 1, 0, 0, 1), // R4 gone
    v(4, 1, 2'b00, 0, 1, 0, 4'd7, 16'h0000, 2'd1, 1, 0, 0, 1), // R4 gone
    v(11, 0, 2'b00, 0, 0, 1, 4'd0, 16'h0000, 2'd0, 0, 0, 0, 0), // R11 clr
    v(5, 1, 2'b00, 0, 0, 0, 4'd3, 16'h0000, 2'd2, 0, 0, 1, 0), // R5
    v(8, 1, 2'b01, 0, 0, 0, 4'd3, 16'h5555, 2'd1, 0, 0, 0, 1), // R8
    v(8, 1, 2'b00, 0, 1, 0, 4'd3, 16'h1111, 2'd1, 1, 0, 0, 1), // R8 kept
    v(11, 0, 2'b00, 0, 0, 1, 4'd0, 16'h0000, 2'd0, 0, 0, 0, 0), // R11 clr
    v(9, 1, 2'b00, 1, 1, 0, 4'd3, 16'h0000, 2'd3, 0, 0, 0, 0), // R9
    v(10, 1, 2'b01, 1, 1, 0, 4'd3, 16'h6666, 2'd1, 0, 0, 0, 0), // R10
    v(10, 1, 2'b00, 0, 1, 0, 4'd3, 16'h1111, 2'd1, 1, 0, 0, 0), // R10 kept
    v(9, 1, 2'b00, 1, 0, 0, 4'd4, 16'h0000, 2'd3, 0, 0, 0, 0), // R9 busy
    v(10, 1, 2'b01, 1, 0, 0, 4'd4, 16'h7777, 2'd1, 0, 0, 0, 0), // R10 busy
    v(2, 1, 2'b01, 0, 0, 0, 4'd8, 16'h7777, 2'd1, 0, 1, 0, 0), // R2 post
    v(11, 1, 2'b01, 0, 0, 1, 4'd8, 16'h8888, 2'd1, 0, 0, 0, 1), // R11 set wins
    v(11, 0, 2'b00, 0, 0, 1, 4'd0, 16'h0000, 2'd0, 0, 0, 0, 0)  // R11 clr
  };

  task automatic chk(bit ok, string rq, string what, int act, int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s actual=%0h expected=%0h", rq, what, act, exp);
    end
  endtask

  task automatic drive(bit rv, logic [1:0] cmd, bit ap, bit g, bit c,
                       logic [3:0] a, logic [15:0] d);
    bus_req = rv; bus_cmd = cmd; bus_aperr = ap; mem_gnt = g;
    err_clr = c; bus_addr = a; bus_wdata = d;
  endtask

  task automatic chk_status(string rq, bit pw, bit rp, bit er);
    chk(pw_pending == pw, rq, "pw_pending", pw_pending, pw);
    chk(rd_pending == rp, rq, "rd_pending", rd_pending, rp);
    chk(err_flag == er, rq, "err_flag", err_flag, er);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R12 reset state
    chk(rsp_valid == 1'b0, "R12", "rsp_valid", rsp_valid, 0);
    chk(mem_req == 1'b0, "R12", "mem_req", mem_req, 0);
    chk_status("R12", 0, 0, 0);

    for (int k = 0; k < NV; k++) begin
      logic [35:0] e;
      string rq;
      e  = VEC[k];
      rq = rq_name(int'(e[35:32]));
      drive(e[31], e[30:29], e[28], e[27], e[26], e[25:22], e[21:6]);
      @(negedge clk);
      drive(0, 2'b00, 0, 0, 0, 4'd0, 16'h0);
      chk(rsp_valid == e[31], rq, $sformatf("step %0d rsp_valid", k),
          rsp_valid, e[31]);
      if (e[31])
        chk(rsp_code == e[5:4], rq, $sformatf("step %0d rsp_code", k),
            rsp_code, e[5:4]);
      if (e[3])
        chk(rsp_rdata == e[21:6], rq, $sformatf("step %0d rsp_rdata", k),
            rsp_rdata, e[21:6]);
      chk_status(rq, e[2], e[1], e[0]);
    end

    // R2 directed: mem_req held across refused cycles, then commit
    drive(1, 2'b01, 0, 0, 0, 4'd9, 16'hABCD);
    @(negedge clk);
    drive(0, 2'b00, 0, 0, 0, 4'd0, 16'h0);
    for (int j = 0; j < 3; j++) begin
      chk(mem_req == 1'b1, "R2", "mem_req held", mem_req, 1);
      chk(pw_pending == 1'b1, "R2", "pw held", pw_pending, 1);
      @(negedge clk);
    end
    mem_gnt = 1'b1;
    @(negedge clk);
    mem_gnt = 1'b0;
    chk(mem_req == 1'b0, "R2", "mem_req after grant", mem_req, 0);
    chk(pw_pending == 1'b0, "R2", "pw after grant", pw_pending, 0);
    chk(mem[9] == 16'hABCD, "R2", "memory word", mem[9], 16'hABCD);

    // R5 directed: parked read raises mem_req, dropped after fetch grant
    drive(1, 2'b10, 0, 0, 0, 4'd9, 16'h0);
    @(negedge clk);
    drive(0, 2'b00, 0, 0, 0, 4'd0, 16'h0);
    chk(mem_req == 1'b1, "R5", "mem_req for read", mem_req, 1);
    chk(rsp_code == 2'd2, "R5", "retry", rsp_code, 2);
    mem_gnt = 1'b1;
    @(negedge clk);
    mem_gnt = 1'b0;
    chk(mem_req == 1'b0, "R5", "mem_req after fetch", mem_req, 0);
    @(negedge clk);
    // R7 matching qualifier command returns the fetched word
    drive(1, 2'b10, 0, 0, 0, 4'd9, 16'h0);
    @(negedge clk);
    drive(0, 2'b00, 0, 0, 0, 4'd0, 16'h0);
    chk(rsp_code == 2'd1, "R7", "hit code", rsp_code, 1);
    chk(rsp_rdata == 16'hABCD, "R7", "hit data", rsp_rdata, 16'hABCD);
    chk(rd_pending == 1'b0, "R7", "slot freed", rd_pending, 0);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule